// File: doc/BRIEF.md
# Program/Erase Status Poll Generator

This block produces the word a host sees when it reads a flash bank while an embedded program or erase is under way. It follows the operation that has just been started, the busy and suspend flags from the operation engine and the sector-protection result, and it answers each read with either a status word or the array data presented on an external input. The status word carries a polling bit in bit 7 and a toggle bit in bit 6. The polling bit's meaning depends on the operation: it is the inverted datum bit while a program runs, and a fixed level during an erase or erase suspend.

An operation begins on the cycle where `op_start` is high, which marks the last write strobe of the command sequence. A program or erase aimed only at protected sectors never reaches the engine. The block runs a protection timer for a fixed, parameterised number of cycles and then returns the bank to read mode. A program issued while an erase is suspended reports status like any program. When it ends, the bank goes back to reporting the suspended erase. For a buffered program, the status is flagged as meaningful only when the read address matches the last word written to the buffer.

Reads have one cycle of latency: `rd_en` and `rd_addr` are sampled on a clock edge, and the answer appears on `rd_valid`, `rd_data`, `rd_status` and `rd_stat_ok` after that edge. Status decisions use the block's state as it was before that edge.

Top module: `poll_status_gen`

## Requirements
- R1: When the bank is idle, a read sampled on an edge returns `arr_data` unchanged on `rd_data`, one cycle later, with `rd_valid`=1, `rd_status`=0 and `rd_stat_ok`=0. After reset, `rd_valid`, `rd_status` and `rd_stat_ok` are 0.
- R2: While a program runs, a read from the first edge after the `op_start` edge onward returns a status word (`rd_status`=1) whose bit 7 is the inverse of bit 7 of the datum latched at `op_start`.
- R3: A program ends once the engine has shown `eng_busy`=1 and then shows `eng_busy`=0. The bank is then idle and reads return array data.
- R4: While an erase runs and `eng_susp`=0, status bit 7 is 0. While the erase is suspended (`eng_susp`=1), status bit 7 is 1 and bit 6 holds its value across reads.
- R5: An erase ends when the engine has shown busy and then shows `eng_busy`=0 with `eng_susp`=0. The bank is then idle.
- R6: Bit 6 of the status word inverts after every status read while the bank is not in erase suspend. It is 0 after reset and keeps its value between operations.
- R7: For a program with `op_buf`=1, `rd_stat_ok` is 1 only when `rd_addr` equals the `op_addr` latched at start. For `op_buf`=0, and for erases, every status read has `rd_stat_ok`=1.
- R8: A program started with `op_prot`=1 returns program status for exactly `PGM_TMO` cycles of read edges after the start edge, regardless of the engine flags. The bank is then idle.
- R9: An erase started with `op_prot`=1 (all selected sectors protected) returns status with bit 7 = 0 for exactly `ERS_TMO` cycles. The bank is then idle.
- R10: A program started while an erase is suspended reports program status as in R2, or as in R8 if protected. When it ends, the bank reports suspended-erase status again (bit 7 = 1).
- R11: An `op_start` while an operation is running is ignored. The one exception is a program start during erase suspend.
- R12: In a status word, every bit other than bits 7 and 6 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Final write strobe of a program or erase command |
| op_erase | input | 1 | 1 = erase, 0 = program (with `op_start`) |
| op_buf | input | 1 | Program is a buffered program (with `op_start`) |
| op_data | input | DW | Datum being programmed; for a buffered program, that of the last word |
| op_addr | input | AW | Program address; for a buffered program, the last word's address |
| op_prot | input | 1 | Target sector protected (program) or all selected sectors protected (erase) |
| eng_busy | input | 1 | Engine is running an embedded algorithm |
| eng_susp | input | 1 | Bank is in erase suspend |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read address |
| arr_data | input | DW | Array data for the read address |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | DW | Status word or array data |
| rd_status | output | 1 | `rd_data` holds a status word |
| rd_stat_ok | output | 1 | Status word is meaningful for this address |

## Verification
The checker watches several properties on every cycle. Idle reads pass array data through with one cycle of latency. The meaningful flag never appears without a status word. Unused status bits are zero. Bit 7 matches the erase-running and erase-suspended levels. No protection timeout outlasts its longest interval. Other behaviour spans many reads and can only be shown by the bench's scenarios: the inverted program bit, the toggle sequence, the buffered last-word flag, the exact timeout lengths, ignored starts, and the return to suspended-erase status after a nested program.

// File: rtl/poll_status_pkg.sv
package poll_status_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PGM  = 2'd1,
      ST_ERS  = 2'd2,
      ST_TMO  = 2'd3
   } pstat_state_e;
endpackage

// File: rtl/poll_prot_timer.sv
module poll_prot_timer #(
   parameter int PGM_TMO = 64,
   parameter int ERS_TMO = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic load_ers,
   output logic expired
);
   localparam int MAXT = (PGM_TMO > ERS_TMO) ? PGM_TMO : ERS_TMO;
   localparam int CW   = $clog2(MAXT + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] load_val;

   generate
      if (PGM_TMO == ERS_TMO) begin : g_shared
         assign load_val = CW'(PGM_TMO - 1);
      end else begin : g_split
         assign load_val = load_ers ? CW'(ERS_TMO - 1) : CW'(PGM_TMO - 1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/poll_op_ctrl.sv
module poll_op_ctrl
   import poll_status_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_start,
   input  logic         op_erase,
   input  logic         op_prot,
   input  logic         eng_busy,
   input  logic         eng_susp,
   input  logic         tmo_done,
   output pstat_state_e st,
   output logic         take,
   output logic         tmo_load,
   output logic         tmo_is_ers
);
   pstat_state_e nxt;
   logic armed;
   logic held;

   assign take = op_start &&
                 ((st == ST_IDLE) || (st == ST_ERS && eng_susp && !op_erase));
   assign tmo_load = take && op_prot;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE: if (take) nxt = op_prot ? ST_TMO : (op_erase ? ST_ERS : ST_PGM);
         ST_PGM:  if (armed && !eng_busy) nxt = held ? ST_ERS : ST_IDLE;
         ST_ERS: begin
            if (take)
               nxt = op_prot ? ST_TMO : ST_PGM;
            else if (armed && !eng_busy && !eng_susp)
               nxt = ST_IDLE;
         end
         ST_TMO:  if (tmo_done) nxt = held ? ST_ERS : ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         armed      <= 1'b0;
         held       <= 1'b0;
         tmo_is_ers <= 1'b0;
      end else begin
         st <= nxt;
         if (take)
            armed <= 1'b0;
         else if ((nxt == ST_ERS && st != ST_ERS) || eng_busy)
            armed <= 1'b1;
         if (take)
            held <= (st == ST_ERS);
         else if (nxt == ST_ERS && st != ST_ERS)
            held <= 1'b0;
         if (take)
            tmo_is_ers <= op_erase;
      end
   end
endmodule

// File: rtl/poll_read_fmt.sv
module poll_read_fmt
   import poll_status_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pstat_state_e  st,
   input  logic          eng_susp,
   input  logic          tmo_is_ers,
   input  logic          ctx_d7,
   input  logic          ctx_buf,
   input  logic [AW-1:0] ctx_addr,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] arr_data,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          rd_status,
   output logic          rd_stat_ok
);
   localparam int POLL_BIT = 7;
   localparam int TGL_BIT  = 6;

   logic          active;
   logic          frozen;
   logic          ers_view;
   logic          poll;
   logic          ok;
   logic          tgl;
   logic [DW-1:0] sword;

   assign active   = (st != ST_IDLE);
   assign frozen   = (st == ST_ERS) && eng_susp;
   assign ers_view = (st == ST_ERS) || (st == ST_TMO && tmo_is_ers);

   always_comb begin
      if (st == ST_ERS)
         poll = eng_susp;
      else if (ers_view)
         poll = 1'b0;
      else
         poll = ~ctx_d7;
      ok = ers_view || !ctx_buf || (rd_addr == ctx_addr);
      sword           = '0;
      sword[POLL_BIT] = poll;
      sword[TGL_BIT]  = tgl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgl        <= 1'b0;
         rd_valid   <= 1'b0;
         rd_status  <= 1'b0;
         rd_stat_ok <= 1'b0;
         rd_data    <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_status  <= active;
            rd_stat_ok <= active && ok;
            rd_data    <= active ? sword : arr_data;
            if (active && !frozen)
               tgl <= ~tgl;
         end else begin
            rd_status  <= 1'b0;
            rd_stat_ok <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/poll_status_gen.sv
module poll_status_gen
   import poll_status_pkg::*;
#(
   parameter int DW      = 16,
   parameter int AW      = 20,
   parameter int PGM_TMO = 64,
   parameter int ERS_TMO = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_start,
   input  logic          op_erase,
   input  logic          op_buf,
   input  logic [DW-1:0] op_data,
   input  logic [AW-1:0] op_addr,
   input  logic          op_prot,
   input  logic          eng_busy,
   input  logic          eng_susp,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] arr_data,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          rd_status,
   output logic          rd_stat_ok
);
   generate
      if (DW < 8) begin : g_dw_chk
         $error("poll_status_gen: DW must be at least 8");
      end
      if (AW < 1) begin : g_aw_chk
         $error("poll_status_gen: AW must be at least 1");
      end
      if (PGM_TMO < 1 || ERS_TMO < 1) begin : g_tmo_chk
         $error("poll_status_gen: timeouts must be at least one cycle");
      end
   endgenerate

   pstat_state_e  st;
   logic          take;
   logic          tmo_load;
   logic          tmo_is_ers;
   logic          tmo_done;
   logic          ctx_d7;
   logic          ctx_buf;
   logic [AW-1:0] ctx_addr;

   poll_op_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_start   (op_start),
      .op_erase   (op_erase),
      .op_prot    (op_prot),
      .eng_busy   (eng_busy),
      .eng_susp   (eng_susp),
      .tmo_done   (tmo_done),
      .st         (st),
      .take       (take),
      .tmo_load   (tmo_load),
      .tmo_is_ers (tmo_is_ers)
   );

   poll_prot_timer #(.PGM_TMO(PGM_TMO), .ERS_TMO(ERS_TMO)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmo_load),
      .load_ers (op_erase),
      .expired  (tmo_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_d7   <= 1'b0;
         ctx_buf  <= 1'b0;
         ctx_addr <= '0;
      end else if (take) begin
         ctx_d7   <= op_data[7];
         ctx_buf  <= op_buf && !op_erase;
         ctx_addr <= op_addr;
      end
   end

   poll_read_fmt #(.DW(DW), .AW(AW)) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .st         (st),
      .eng_susp   (eng_susp),
      .tmo_is_ers (tmo_is_ers),
      .ctx_d7     (ctx_d7),
      .ctx_buf    (ctx_buf),
      .ctx_addr   (ctx_addr),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .arr_data   (arr_data),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .rd_status  (rd_status),
      .rd_stat_ok (rd_stat_ok)
   );
endmodule

// File: rtl/poll_status_chk.sv
module poll_status_chk
   import poll_status_pkg::*;
#(
   parameter int DW      = 16,
   parameter int PGM_TMO = 64,
   parameter int ERS_TMO = 256
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_en,
   input logic          rd_valid,
   input logic [DW-1:0] rd_data,
   input logic          rd_status,
   input logic          rd_stat_ok,
   input logic [DW-1:0] arr_data,
   input logic          eng_susp,
   input pstat_state_e  st
);
   localparam int MAXT = (PGM_TMO > ERS_TMO) ? PGM_TMO : ERS_TMO;
   localparam int RW   = $clog2(MAXT + 2);
   localparam logic [DW-1:0] FREE_MASK = ~(DW'(8'hC0));

   logic [RW-1:0] tmo_run;
   always_ff @(posedge clk) begin
      if (!rst_n)
         tmo_run <= '0;
      else if (st == ST_TMO && tmo_run <= RW'(MAXT))
         tmo_run <= tmo_run + 1'b1;
      else if (st != ST_TMO)
         tmo_run <= '0;
   end

   p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_status) |-> rd_data == $past(arr_data));

   p_idle_no_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(st == ST_IDLE)) |-> !rd_status);

   p_ok_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat_ok |-> (rd_status && rd_valid));

   p_free_bits_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status |-> (rd_data & FREE_MASK) == '0);

   p_erase_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_status && $past(st == ST_ERS && !eng_susp)) |-> !rd_data[7]);

   p_susp_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_status && $past(st == ST_ERS && eng_susp)) |-> rd_data[7]);

   p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_run <= RW'(MAXT));
endmodule

bind poll_status_gen poll_status_chk #(
   .DW(DW), .PGM_TMO(PGM_TMO), .ERS_TMO(ERS_TMO)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data),
   .rd_status  (rd_status),
   .rd_stat_ok (rd_stat_ok),
   .arr_data   (arr_data),
   .eng_susp   (eng_susp),
   .st         (st)
);

// File: tb/poll_status_gen_tb_top.sv
`timescale 1ns/1ps
module poll_status_gen_tb_top;
   localparam int DW = 16;
   localparam int AW = 12;
   localparam int PT = 12;
   localparam int ET = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_start = 1'b0, op_erase = 1'b0, op_buf = 1'b0, op_prot = 1'b0;
   logic [DW-1:0] op_data = '0;
   logic [AW-1:0] op_addr = '0;
   logic          eng_busy = 1'b0, eng_susp = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] arr_data = '0;
   logic          rd_valid, rd_status, rd_stat_ok;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic tog_m = 1'b0;
   logic [DW+1:0] exp_q[$];
   string         tag_q[$];

   always #4 clk = ~clk;

   poll_status_gen #(.DW(DW), .AW(AW), .PGM_TMO(PT), .ERS_TMO(ET)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
      .op_buf(op_buf), .op_data(op_data), .op_addr(op_addr), .op_prot(op_prot),
      .eng_busy(eng_busy), .eng_susp(eng_susp), .rd_en(rd_en), .rd_addr(rd_addr),
      .arr_data(arr_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_status(rd_status), .rd_stat_ok(rd_stat_ok)
   );

   task automatic check(input bit cond, input string tag, input logic [DW+1:0] act,
                        input logic [DW+1:0] exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected items as answers appear
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         logic [DW+1:0] act;
         act = {rd_status, rd_stat_ok, rd_data};
         if (exp_q.size() == 0)
            check(1'b0, "unexpected answer", act, '0);
         else begin
            logic [DW+1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(act == e, t, act, e);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_op(input logic er, input logic bf, input logic [DW-1:0] d,
                           input logic [AW-1:0] a, input logic pr);
      op_erase = er; op_buf = bf; op_data = d; op_addr = a; op_prot = pr;
      op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0;
   endtask

   // driver: status read, expected word from the requirement model
   task automatic rd_stat(input logic [AW-1:0] a, input logic b7, input logic ok,
                          input logic susp, input string tag);
      logic [DW-1:0] w;
      w = '0; w[7] = b7; w[6] = tog_m;
      if (!susp) tog_m = ~tog_m;
      exp_q.push_back({1'b1, ok, w});
      tag_q.push_back(tag);
      rd_addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_arr(input logic [AW-1:0] a, input logic [DW-1:0] v, input string tag);
      arr_data = v;
      exp_q.push_back({2'b00, v});
      tag_q.push_back(tag);
      rd_addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      check(!rd_valid && !rd_status && !rd_stat_ok, "R1 reset outputs",
            {rd_status, rd_stat_ok, rd_data}, '0);
      rd_arr(12'h010, 16'hA55A, "R1 idle passthrough");
      rd_arr(12'h011, 16'h3C81, "R1 idle passthrough second");

      // plain program, datum bit7 = 1 -> status bit7 = 0
      start_op(1'b0, 1'b0, 16'h0080, 12'h100, 1'b0);
      rd_stat(12'h200, 1'b0, 1'b1, 1'b0, "R2 program inverted bit7");
      rd_stat(12'h100, 1'b0, 1'b1, 1'b0, "R6 toggle after read");
      eng_busy = 1'b1; cyc(2);
      start_op(1'b1, 1'b0, 16'h0000, 12'h000, 1'b0);
      rd_stat(12'h100, 1'b0, 1'b1, 1'b0, "R11 erase start ignored while busy");
      rd_stat(12'h100, 1'b0, 1'b1, 1'b0, "R12 status word fields");
      eng_busy = 1'b0; cyc(2);
      rd_arr(12'h100, 16'h0080, "R3 program done returns array");

      // buffered program, datum bit7 = 0 -> status bit7 = 1
      start_op(1'b0, 1'b1, 16'h1234, 12'h123, 1'b0);
      rd_stat(12'h123, 1'b1, 1'b1, 1'b0, "R7 buffered last word ok");
      rd_stat(12'h120, 1'b1, 1'b0, 1'b0, "R7 buffered other word not ok");
      eng_busy = 1'b1; cyc(3); eng_busy = 1'b0; cyc(2);
      rd_arr(12'h123, 16'h1234, "R3 buffered program done");

      // erase with suspend and nested program
      start_op(1'b1, 1'b0, 16'h0000, 12'h000, 1'b0);
      rd_stat(12'h300, 1'b0, 1'b1, 1'b0, "R4 erase bit7 low");
      eng_busy = 1'b1; cyc(2);
      rd_stat(12'h301, 1'b0, 1'b1, 1'b0, "R4 erase busy bit7 low");
      eng_busy = 1'b0; eng_susp = 1'b1; cyc(2);
      rd_stat(12'h300, 1'b1, 1'b1, 1'b1, "R4 suspend bit7 high");
      rd_stat(12'h300, 1'b1, 1'b1, 1'b1, "R4 suspend toggle frozen");
      start_op(1'b0, 1'b0, 16'h00FF, 12'h055, 1'b0);
      rd_stat(12'h055, 1'b0, 1'b1, 1'b0, "R10 program in suspend");
      rd_stat(12'h055, 1'b0, 1'b1, 1'b0, "R10 program in suspend toggles");
      eng_busy = 1'b1; cyc(2); eng_busy = 1'b0; cyc(2);
      rd_stat(12'h300, 1'b1, 1'b1, 1'b1, "R10 back to suspended erase");
      eng_susp = 1'b0; eng_busy = 1'b1; cyc(2);
      rd_stat(12'h300, 1'b0, 1'b1, 1'b0, "R4 resumed erase bit7 low");
      eng_busy = 1'b0; cyc(2);
      rd_arr(12'h300, 16'hFFFF, "R5 erase done returns array");

      // protected program timeout
      start_op(1'b0, 1'b0, 16'h0000, 12'h0A0, 1'b1);
      eng_busy = 1'b1;
      rd_stat(12'h0A0, 1'b1, 1'b1, 1'b0, "R8 protected program first cycle");
      eng_busy = 1'b0;
      cyc(PT - 2);
      rd_stat(12'h0A0, 1'b1, 1'b1, 1'b0, "R8 protected program last cycle");
      rd_arr(12'h0A0, 16'h5A5A, "R8 protected program ends");

      // protected erase timeout
      start_op(1'b1, 1'b0, 16'h0080, 12'h0B0, 1'b1);
      rd_stat(12'h0B0, 1'b0, 1'b1, 1'b0, "R9 protected erase first cycle");
      cyc(ET - 2);
      rd_stat(12'h0B0, 1'b0, 1'b1, 1'b0, "R9 protected erase last cycle");
      rd_arr(12'h0B0, 16'h7E01, "R9 protected erase ends");

      cyc(3);
      check(exp_q.size() == 0, "R1 all answers returned",
            (DW+2)'(exp_q.size()), '0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule